// File: doc/BRIEF.md
# Dual-Sided Processor Mailbox Core

This block joins two processors, called side A and side B. Each side has its own small register bank. Each side owns four 32-bit outgoing message slots. A word written into outgoing slot n on one side is held in the core and read back from incoming slot n on the other side. Each channel has two flags that track whether it is occupied. On the sender these appear as transmit-empty. On the receiver they appear as receive-full. The two flags always give opposite views of the same occupancy.

Alongside the data channels, each side can ring any of four doorbells toward its partner. A rung doorbell shows up on the far side as a pending bit. That bit stays set until the far side clears it by writing a one to it. Each side has one combined interrupt line. The line is the OR of every flag whose per-channel enable is set. Either side can also start a short reset of the whole unit by writing a control bit. This reset is timed by the core.

Each port is a plain single-cycle register interface. A read returns data combinationally in the cycle its strobe is high. Its side effects take place at the following clock edge. There is no back-pressure: every access is accepted in the cycle it is presented.

Top module: `mu_core`

## Requirements
- R1: A write to word address n (0 to 3) stores the word for channel n and takes effect at the next edge. From then on, transmit-empty n reads 0 on the writing side and receive-full n reads 1 on the other side.
- R2: A read of word address 4+n returns the word last sent on channel n by the far side. At the next edge it clears receive-full n on the reader and sets transmit-empty n on the sender.
- R3: If the sender writes channel n in the same cycle the receiver reads it, the read returns the old word, the new word is stored, and receive-full n stays 1.
- R4: The status word is at word address 8. The flags for channel n sit at these bits: doorbell-pending at 31−n, receive-full at 27−n, transmit-empty at 23−n. Bit 7 reads 1 while a unit reset is in progress. All other bits read 0.
- R5: The control word is at word address 9. The bits for channel n are: doorbell enable at 31−n, receive enable at 27−n, transmit enable at 23−n, doorbell request at 19−n. Bit 5 starts a unit reset and always reads 0.
- R6: Writing doorbell request n on one side makes it read 1 for one cycle. At the following edge it sets doorbell-pending n on the other side and clears itself.
- R7: Writing status with bit 31−n set clears doorbell-pending n. A zero bit has no effect. If a new doorbell arrives in the same cycle as the clear, the pending bit stays 1.
- R8: A side's interrupt output is high exactly when at least one of its doorbell-pending, receive-full or transmit-empty flags has its matching enable set.
- R9: Writing control with bit 5 set starts a unit reset lasting 4 cycles, during which status bit 7 reads 1. During the reset, every write and every read side effect on both sides is ignored, and both interrupt lines stay low. At and after the reset, all control bits on both sides read 0, transmit-empty is 1 on every channel, and receive-full and doorbell-pending are 0.
- R10: After the asynchronous reset, both status words read 0x00F00000 and both control words read 0.
- R11: Writes to incoming-slot addresses (4 to 7) are ignored. Status writes change only the doorbell-pending bits. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_wr_en | input | 1 | Side A write strobe |
| a_rd_en | input | 1 | Side A read strobe |
| a_addr | input | AW | Side A word address |
| a_wdata | input | DW | Side A write data |
| a_rdata | output | DW | Side A read data, 0 when no read is in progress |
| a_irq | output | 1 | Side A combined interrupt |
| b_wr_en | input | 1 | Side B write strobe |
| b_rd_en | input | 1 | Side B read strobe |
| b_addr | input | AW | Side B word address |
| b_wdata | input | DW | Side B write data |
| b_rdata | output | DW | Side B read data, 0 when no read is in progress |
| b_irq | output | 1 | Side B combined interrupt |

## Verification
The bench builds the core with its defaults: 32-bit data, a 4-bit word address, and a 4-cycle reset window. The short window lets a read issued in each cycle observe every cycle of the unit reset, including a write that is dropped partway through and the first cycle after the window ends. With 4-bit addresses, the unmapped words 10 to 15 can be reached, so the zero read-back can be checked. A one-cycle doorbell request can also be caught between the write and its arrival on the far side.

// File: rtl/mu_pkg.sv
package mu_pkg;
  // Channel count is fixed by the packed flag layout
  localparam int NCH      = 4;
  localparam int IDX_W    = 2;
  // Status word lanes
  localparam int GIP_LSB  = 28;
  localparam int RF_LSB   = 24;
  localparam int TE_LSB   = 20;
  localparam int BUSY_BIT = 7;
  // Control word lanes
  localparam int GIE_LSB  = 28;
  localparam int RIE_LSB  = 24;
  localparam int TIE_LSB  = 20;
  localparam int GIR_LSB  = 16;
  localparam int RST_BIT  = 5;

  // Channel n lives at the top of its group, channel 3 at the bottom
  function automatic int lane(input int lsb, input int n);
    return lsb + NCH - 1 - n;
  endfunction
endpackage

// File: rtl/mu_reset_seq.sv
module mu_reset_seq #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic busy,
  output logic clr
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (req)        cnt <= CW'(RST_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
  // The clear also acts on the accepting edge, so state is clean in every busy cycle
  assign clr  = busy | req;
endmodule

// File: rtl/mu_mailbox.sv
module mu_mailbox
  import mu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic [1:0]                     wr_en,
  input  logic [1:0][IDX_W-1:0]          wr_idx,
  input  logic [1:0][DW-1:0]             wdata,
  input  logic [1:0]                     rd_en,
  input  logic [1:0][IDX_W-1:0]          rd_idx,
  // full[d][n]: channel n travelling away from side d holds an unread word
  output logic [1:0][NCH-1:0]            full,
  output logic [1:0][NCH-1:0][DW-1:0]    slot
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= '0;
      slot <= '0;
    end else begin
      for (int d = 0; d < 2; d++) begin
        for (int n = 0; n < NCH; n++) begin
          if (clr) begin
            full[d][n] <= 1'b0;
          end else if (wr_en[d] && wr_idx[d] == IDX_W'(n)) begin
            // A write beats a same-cycle read of the far side
            full[d][n] <= 1'b1;
            slot[d][n] <= wdata[d];
          end else if (rd_en[1-d] && rd_idx[1-d] == IDX_W'(n)) begin
            full[d][n] <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mu_side_regs.sv
module mu_side_regs
  import mu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           busy,
  input  logic           ctrl_we,
  input  logic           stat_we,
  input  logic [DW-1:0]  wdata,
  input  logic [NCH-1:0] ring_in,
  input  logic [NCH-1:0] te,
  input  logic [NCH-1:0] rf,
  output logic [NCH-1:0] gir,
  output logic [NCH-1:0] gip,
  output logic           irq,
  output logic [DW-1:0]  stat_word,
  output logic [DW-1:0]  ctrl_word
);
  logic [NCH-1:0] gie, rie, tie;
  logic [NCH-1:0] gie_w, rie_w, tie_w, gir_w, w1c;

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      gie_w[n] = wdata[lane(GIE_LSB, n)];
      rie_w[n] = wdata[lane(RIE_LSB, n)];
      tie_w[n] = wdata[lane(TIE_LSB, n)];
      gir_w[n] = wdata[lane(GIR_LSB, n)];
      w1c[n]   = stat_we & wdata[lane(GIP_LSB, n)];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie <= '0; rie <= '0; tie <= '0; gir <= '0; gip <= '0;
    end else if (clr) begin
      gie <= '0; rie <= '0; tie <= '0; gir <= '0; gip <= '0;
    end else begin
      if (ctrl_we) begin
        gie <= gie_w;
        rie <= rie_w;
        tie <= tie_w;
      end
      // A request lives one cycle: the far side latches it at the next edge
      gir <= ctrl_we ? gir_w : '0;
      gip <= (gip & ~w1c) | ring_in;
    end
  end

  assign irq = |(gip & gie) | |(rf & rie) | |(te & tie);

  always_comb begin
    stat_word = '0;
    ctrl_word = '0;
    for (int n = 0; n < NCH; n++) begin
      stat_word[lane(GIP_LSB, n)] = gip[n];
      stat_word[lane(RF_LSB, n)]  = rf[n];
      stat_word[lane(TE_LSB, n)]  = te[n];
      ctrl_word[lane(GIE_LSB, n)] = gie[n];
      ctrl_word[lane(RIE_LSB, n)] = rie[n];
      ctrl_word[lane(TIE_LSB, n)] = tie[n];
      ctrl_word[lane(GIR_LSB, n)] = gir[n];
    end
    stat_word[BUSY_BIT] = busy;
  end
endmodule

// File: rtl/mu_core.sv
module mu_core
  import mu_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 4,
  parameter int RST_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr_en,
  input  logic          a_rd_en,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_irq,
  input  logic          b_wr_en,
  input  logic          b_rd_en,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_irq
);
  localparam logic [AW-1:0] RX_BASE = AW'(NCH);
  localparam logic [AW-1:0] ST_ADDR = AW'(2 * NCH);
  localparam logic [AW-1:0] CT_ADDR = AW'(2 * NCH + 1);

  logic [1:0]                  wr_v, rd_v, irq_v;
  logic [1:0][AW-1:0]          addr_v;
  logic [1:0][DW-1:0]          wdata_v, rdata_v;
  logic [1:0]                  tx_we, rx_re, st_we, ct_we;
  logic [1:0][IDX_W-1:0]       idx_v;
  logic [1:0][NCH-1:0]         full_v, gir_v, gip_v;
  logic [1:0][NCH-1:0][DW-1:0] slot_v;
  logic [1:0][DW-1:0]          stat_v, ctrl_v;
  logic                        rst_req, busy, clr;

  assign wr_v    = {b_wr_en, a_wr_en};
  assign rd_v    = {b_rd_en, a_rd_en};
  assign addr_v  = {b_addr, a_addr};
  assign wdata_v = {b_wdata, a_wdata};
  assign a_rdata = rdata_v[0];
  assign b_rdata = rdata_v[1];
  assign a_irq   = irq_v[0];
  assign b_irq   = irq_v[1];

  assign rst_req = |(ct_we & {b_wdata[RST_BIT], a_wdata[RST_BIT]});

  mu_reset_seq #(.RST_CYCLES(RST_CYCLES)) rst_seq_i (
    .clk(clk), .rst_n(rst_n), .req(rst_req), .busy(busy), .clr(clr)
  );

  mu_mailbox #(.DW(DW)) mbox_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(tx_we), .wr_idx(idx_v), .wdata(wdata_v),
    .rd_en(rx_re), .rd_idx(idx_v),
    .full(full_v), .slot(slot_v)
  );

  for (genvar s = 0; s < 2; s++) begin : g_side
    logic in_tx, in_rx;
    assign idx_v[s]  = addr_v[s][IDX_W-1:0];
    assign in_tx     = addr_v[s] < RX_BASE;
    assign in_rx     = (addr_v[s] >= RX_BASE) && (addr_v[s] < ST_ADDR);
    assign tx_we[s]  = wr_v[s] && !busy && in_tx;
    assign rx_re[s]  = rd_v[s] && !busy && in_rx;
    assign st_we[s]  = wr_v[s] && !busy && (addr_v[s] == ST_ADDR);
    assign ct_we[s]  = wr_v[s] && !busy && (addr_v[s] == CT_ADDR);

    mu_side_regs #(.DW(DW)) regs_i (
      .clk(clk), .rst_n(rst_n), .clr(clr), .busy(busy),
      .ctrl_we(ct_we[s]), .stat_we(st_we[s]), .wdata(wdata_v[s]),
      .ring_in(gir_v[1-s]), .te(~full_v[s]), .rf(full_v[1-s]),
      .gir(gir_v[s]), .gip(gip_v[s]), .irq(irq_v[s]),
      .stat_word(stat_v[s]), .ctrl_word(ctrl_v[s])
    );

    always_comb begin
      rdata_v[s] = '0;
      if (rd_v[s]) begin
        if (in_rx)                         rdata_v[s] = slot_v[1-s][idx_v[s]];
        else if (addr_v[s] == ST_ADDR)     rdata_v[s] = stat_v[s];
        else if (addr_v[s] == CT_ADDR)     rdata_v[s] = ctrl_v[s];
      end
    end
  end
endmodule

// File: rtl/mu_core_chk.sv
module mu_core_chk
  import mu_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  busy,
  input logic                  clr,
  input logic                  a_irq,
  input logic                  b_irq,
  input logic [1:0]            tx_we,
  input logic [1:0][IDX_W-1:0] idx_v,
  input logic [1:0][NCH-1:0]   full_v,
  input logic [1:0][NCH-1:0]   gir_v,
  input logic [1:0][NCH-1:0]   gip_v
);
  localparam int CW = $clog2(RST_CYCLES + 2);
  logic [CW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_len <= '0;
    else if (busy)  busy_len <= busy_len + 1'b1;
    else            busy_len <= '0;
  end

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!a_irq && !b_irq));

  assert_window_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_len == CW'(RST_CYCLES)));

  assert_a_send_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we[0] && !clr) |=> full_v[0][$past(idx_v[0])]);

  assert_b_send_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_we[1] && !clr) |=> full_v[1][$past(idx_v[1])]);

  assert_ring_arrives_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|gir_v[0]) && !clr) |=> ((gip_v[1] & $past(gir_v[0])) == $past(gir_v[0])));
endmodule

bind mu_core mu_core_chk #(.RST_CYCLES(RST_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .clr(clr),
  .a_irq(a_irq), .b_irq(b_irq), .tx_we(tx_we), .idx_v(idx_v),
  .full_v(full_v), .gir_v(gir_v), .gip_v(gip_v)
);

// File: tb/mu_core_tb.sv
`timescale 1ns/1ps
module mu_core_tb_top;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int NV = 38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_irq, b_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  mu_core #(.DW(DW), .AW(AW), .RST_CYCLES(4)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_irq(a_irq),
    .b_wr_en(b_wr_en), .b_rd_en(b_rd_en), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_irq(b_irq)
  );

  // {req, side(1=B), wr, addr, wdata, expected rdata, expected {b_irq,a_irq}}
  localparam logic [75:0] VEC [NV] = '{
    {4'd10, 1'b0, 1'b0, 4'd8, 32'h0,        32'h00F00000, 2'b00}, // R10
    {4'd1,  1'b0, 1'b1, 4'd0, 32'hCAFE0001, 32'h0,        2'b00}, // R1
    {4'd1,  1'b0, 1'b0, 4'd8, 32'h0,        32'h00700000, 2'b00}, // R1
    {4'd4,  1'b1, 1'b0, 4'd8, 32'h0,        32'h08F00000, 2'b00}, // R4
    {4'd5,  1'b1, 1'b1, 4'd9, 32'h08000000, 32'h0,        2'b00}, // R5
    {4'd8,  1'b1, 1'b0, 4'd9, 32'h0,        32'h08000000, 2'b10}, // R8
    {4'd2,  1'b1, 1'b0, 4'd4, 32'h0,        32'hCAFE0001, 2'b10}, // R2
    {4'd2,  1'b1, 1'b0, 4'd8, 32'h0,        32'h00F00000, 2'b00}, // R2
    {4'd2,  1'b0, 1'b0, 4'd8, 32'h0,        32'h00F00000, 2'b00}, // R2
    {4'd5,  1'b0, 1'b1, 4'd9, 32'h00100000, 32'h0,        2'b00}, // R5
    {4'd8,  1'b0, 1'b0, 4'd9, 32'h0,        32'h00100000, 2'b01}, // R8
    {4'd1,  1'b0, 1'b1, 4'd3, 32'h12345678, 32'h0,        2'b01}, // R1
    {4'd4,  1'b0, 1'b0, 4'd8, 32'h0,        32'h00E00000, 2'b00}, // R4
    {4'd2,  1'b1, 1'b0, 4'd7, 32'h0,        32'h12345678, 2'b00}, // R2
    {4'd8,  1'b0, 1'b0, 4'd8, 32'h0,        32'h00F00000, 2'b01}, // R8
    {4'd8,  1'b0, 1'b1, 4'd9, 32'h0,        32'h0,        2'b01}, // R8
    {4'd6,  1'b0, 1'b1, 4'd9, 32'h00020000, 32'h0,        2'b00}, // R6
    {4'd6,  1'b0, 1'b0, 4'd9, 32'h0,        32'h00020000, 2'b00}, // R6
    {4'd6,  1'b0, 1'b0, 4'd9, 32'h0,        32'h0,        2'b00}, // R6
    {4'd6,  1'b1, 1'b0, 4'd8, 32'h0,        32'h20F00000, 2'b00}, // R6
    {4'd5,  1'b1, 1'b1, 4'd9, 32'h20000000, 32'h0,        2'b00}, // R5
    {4'd8,  1'b1, 1'b0, 4'd8, 32'h0,        32'h20F00000, 2'b10}, // R8
    {4'd7,  1'b1, 1'b1, 4'd8, 32'h00000000, 32'h0,        2'b10}, // R7
    {4'd7,  1'b1, 1'b0, 4'd8, 32'h0,        32'h20F00000, 2'b10}, // R7
    {4'd11, 1'b1, 1'b1, 4'd8, 32'hDFFFFFFF, 32'h0,        2'b10}, // R11
    {4'd11, 1'b1, 1'b0, 4'd8, 32'h0,        32'h20F00000, 2'b10}, // R11
    {4'd7,  1'b1, 1'b1, 4'd8, 32'h20000000, 32'h0,        2'b10}, // R7
    {4'd7,  1'b1, 1'b0, 4'd8, 32'h0,        32'h00F00000, 2'b00}, // R7
    {4'd5,  1'b1, 1'b1, 4'd9, 32'h0,        32'h0,        2'b00}, // R5
    {4'd1,  1'b1, 1'b1, 4'd1, 32'hA5A5A5A5, 32'h0,        2'b00}, // R1
    {4'd4,  1'b0, 1'b0, 4'd8, 32'h0,        32'h04F00000, 2'b00}, // R4
    {4'd4,  1'b1, 1'b0, 4'd8, 32'h0,        32'h00B00000, 2'b00}, // R4
    {4'd2,  1'b0, 1'b0, 4'd5, 32'h0,        32'hA5A5A5A5, 2'b00}, // R2
    {4'd2,  1'b0, 1'b0, 4'd8, 32'h0,        32'h00F00000, 2'b00}, // R2
    {4'd11, 1'b0, 1'b0, 4'd12, 32'h0,       32'h0,        2'b00}, // R11
    {4'd11, 1'b0, 1'b1, 4'd5, 32'hFFFFFFFF, 32'h0,        2'b00}, // R11
    {4'd11, 1'b1, 1'b0, 4'd8, 32'h0,        32'h00F00000, 2'b00}, // R11
    {4'd11, 1'b0, 1'b0, 4'd5, 32'h0,        32'hA5A5A5A5, 2'b00}  // R11
  };

  task automatic idle_ports();
    a_wr_en = 0; a_rd_en = 0; b_wr_en = 0; b_rd_en = 0;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
  endtask

  task automatic check(input int req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // One access on one side; rdata and both irqs sampled mid-cycle
  task automatic access(input int req, input bit side, input bit wr,
                        input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                        input logic [DW-1:0] exp, input logic [1:0] irq_exp);
    @(negedge clk);
    idle_ports();
    if (side) begin
      b_wr_en = wr; b_rd_en = !wr; b_addr = addr; b_wdata = wd;
    end else begin
      a_wr_en = wr; a_rd_en = !wr; a_addr = addr; a_wdata = wd;
    end
    #1;
    check(req, "rdata", side ? b_rdata : a_rdata, exp);
    check(req, "irq", {30'd0, b_irq, a_irq}, {30'd0, irq_exp});
  endtask

  task automatic rd(input int req, input bit side, input logic [AW-1:0] addr,
                    input logic [DW-1:0] exp);
    @(negedge clk);
    idle_ports();
    if (side) begin b_rd_en = 1; b_addr = addr; end
    else      begin a_rd_en = 1; a_addr = addr; end
    #1;
    check(req, "rdata", side ? b_rdata : a_rdata, exp);
  endtask

  task automatic wr(input bit side, input logic [AW-1:0] addr, input logic [DW-1:0] wd);
    @(negedge clk);
    idle_ports();
    if (side) begin b_wr_en = 1; b_addr = addr; b_wdata = wd; end
    else      begin a_wr_en = 1; a_addr = addr; a_wdata = wd; end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: reset state of both banks
    rd(10, 1'b0, 4'd9, 32'h0);
    rd(10, 1'b1, 4'd9, 32'h0);
    rd(10, 1'b1, 4'd8, 32'h00F00000);

    for (int i = 0; i < NV; i++) begin
      access(int'(VEC[i][75:72]), VEC[i][71], VEC[i][70], VEC[i][69:66],
             VEC[i][65:34], VEC[i][33:2], VEC[i][1:0]);
    end

    // R3: A writes channel 0 while B reads it
    wr(1'b0, 4'd0, 32'h00000011);
    @(negedge clk);
    idle_ports();
    a_wr_en = 1; a_addr = 4'd0; a_wdata = 32'h00000022;
    b_rd_en = 1; b_addr = 4'd4;
    #1;
    check(3, "collide old word", b_rdata, 32'h00000011);
    rd(3, 1'b1, 4'd8, 32'h08F00000);
    rd(3, 1'b0, 4'd8, 32'h00700000);
    rd(3, 1'b1, 4'd4, 32'h00000022);

    // R7: doorbell 0 arriving in the clearing cycle stays pending
    wr(1'b0, 4'd9, 32'h00080000);
    wr(1'b1, 4'd8, 32'h80000000);
    rd(7, 1'b1, 4'd8, 32'h80F00000);
    wr(1'b1, 4'd8, 32'h80000000);
    rd(7, 1'b1, 4'd8, 32'h00F00000);

    // R9: unit reset from side A
    wr(1'b0, 4'd0, 32'h00000055);
    wr(1'b1, 4'd9, 32'h08000000);
    rd(9, 1'b1, 4'd9, 32'h08000000);
    check(9, "irq before reset", {31'd0, b_irq}, 32'd1);
    wr(1'b0, 4'd9, 32'h00000020);
    rd(9, 1'b0, 4'd8, 32'h00F00080);
    check(9, "irq during reset", {30'd0, b_irq, a_irq}, 32'd0);
    wr(1'b0, 4'd2, 32'h00000077);
    rd(9, 1'b1, 4'd8, 32'h00F00080);
    rd(9, 1'b1, 4'd9, 32'h0);
    rd(9, 1'b0, 4'd8, 32'h00F00000);
    rd(9, 1'b1, 4'd8, 32'h00F00000);
    rd(9, 1'b0, 4'd9, 32'h0);
    check(9, "irq after reset", {30'd0, b_irq, a_irq}, 32'd0);

    // R10: asynchronous reset after traffic
    wr(1'b1, 4'd1, 32'h0000BEEF);
    wr(1'b0, 4'd9, 32'h00F00000);
    @(negedge clk);
    idle_ports();
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(10, 1'b0, 4'd8, 32'h00F00000);
    rd(10, 1'b0, 4'd9, 32'h0);
    rd(10, 1'b1, 4'd8, 32'h00F00000);

    @(negedge clk);
    idle_ports();
    finish_run();
  end
endmodule